// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block turns one vectorised scalar load into a stream of per-element requests. A one-cycle `start` captures a vector length, a source and a destination predicate mask, vector/scalar flags for the base, offset and destination operands, an addressing mode, a signed immediate, an access size and an update flag. The block then walks three element indices:

- `i` selects the base element.
- `k` selects the offset element.
- `j` selects the destination element.

Each index skips the positions that its predicate disables. For every active element the block presents a request carrying the effective address, the source and destination element numbers and an optional write-back of the address into the base register.

The block reads register values through a small read port. It drives `base_idx` and `off_idx`, the element offsets relative to the base and offset registers. The surrounding logic returns `base_rdata` and `off_rdata` combinationally in the same cycle. Requests leave on a valid/ready handshake. Memory access and register storage sit outside the block.

Top module: `vld_addr_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `req_valid` is 0.
- R2: `start` is accepted only while `busy` is 0 and captures all configuration, with `vl` clamped to VL_MAX. Input changes and further `start` pulses during a sequence have no effect on it.
- R3: While `req_valid` is 1 and `req_ready` is 0, the request and all its fields hold unchanged in the next cycle.
- R4: With a vector base in modes 0, 1 or 2, the address is value(base register + i) + imm. No term scaled by the access size is added.
- R5: Mode 1 (unit stride) with a scalar base gives address = value(base register) + (i << `op_size`), where `op_size` 0/1/2/3 means 1/2/4/8 bytes. Here `i` walks the source predicate.
- R6: Mode 2 (element stride) with a scalar base gives address = value(base register) + i × imm, where `i` walks the source predicate.
- R7: Mode 0 (splat) with a scalar base gives address = value(base register) + imm for every element, and the source index stays 0.
- R8: In mode 3 (indexed), address = value(base register + i) + value(offset register + k). `i` steps only for a vector base and `k` only for a vector offset, and both skip on the source predicate.
- R9: Each stepping index skips positions whose predicate bit is 0, independently of the others. `i` and `k` use the source mask, `j` uses the destination mask, and `j` steps only when the destination is a vector.
- R10: The sequence ends without a further request as soon as any index reaches the clamped vector length. With vl = 0, or with an all-zero mask on a stepping index, no request is issued at all.
- R11: With a scalar destination the sequence ends after the first request. In mode 3 with both base and offset scalar it also ends after one request.
- R12: `req_upd` carries the captured update flag. `req_wb_idx` is the base-register element to overwrite: i for a vector base, 0 for a scalar base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| vl | input | IW | Vector length |
| src_pred | input | VL_MAX | Source predicate mask |
| dst_pred | input | VL_MAX | Destination predicate mask |
| base_vec | input | 1 | Base operand is a vector |
| off_vec | input | 1 | Offset operand is a vector |
| dst_vec | input | 1 | Destination is a vector |
| mode | input | 2 | 0 splat, 1 unit stride, 2 element stride, 3 indexed |
| imm | input | AW | Signed immediate |
| op_size | input | 2 | log2 of access size in bytes |
| upd_en | input | 1 | Write effective address back to base |
| base_idx | output | IW | Base register element being read |
| off_idx | output | IW | Offset register element being read |
| base_rdata | input | AW | Value of the base register element |
| off_rdata | input | AW | Value of the offset register element |
| busy | output | 1 | Sequence in progress |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_addr | output | AW | Effective address |
| req_src_idx | output | IW | Source element index i |
| req_dst_idx | output | IW | Destination element index j |
| req_upd | output | 1 | Update write-back requested |
| req_wb_idx | output | IW | Base register element to overwrite |

## Verification
The sweep covers:

- all four modes;
- all eight combinations of vector/scalar flags;
- five mask shapes (full, empty, alternating, sparse ends, middle block);
- vector lengths of zero, partial, full and over-range.

Source and destination masks differ within each run, so the sweep tells independent skipping apart from shared skipping. A scalar base under the stride modes separates stepping `i` from a fixed `i`. The empty masks and vl = 0 separate early termination from a stray first request. Scrambled inputs and a second `start` pulse during each run, together with periodic back-pressure on `req_ready`, show that captured configuration and stalled requests stay put.

// File: rtl/vld_seq_pkg.sv
package vld_seq_pkg;
  typedef enum logic [1:0] {
    M_SPLAT = 2'd0,
    M_UNIT  = 2'd1,
    M_ELEM  = 2'd2,
    M_INDEX = 2'd3
  } ld_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vld_seq_stepper.sv
// One predicated element index: skips disabled positions one per cycle,
// steps after an issued element, parks at the vector length.
module vld_seq_stepper #(
  parameter int VL_MAX = 8,
  parameter int IW     = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              en,
  input  logic              scan,
  input  logic              adv,
  input  logic [IW-1:0]     vl,
  input  logic [VL_MAX-1:0] pred,
  output logic [IW-1:0]     idx,
  output logic              at_end,
  output logic              parked
);
  localparam logic [VL_MAX-1:0] ONE = {{(VL_MAX-1){1'b0}}, 1'b1};

  logic bit_on;

  assign bit_on = |(pred & (ONE << idx));
  assign at_end = (idx >= vl);
  assign parked = !en || at_end || bit_on;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx <= '0;
    end else if (scan && !parked) begin
      idx <= idx + 1'b1;   // R9 skip a masked-off position
    end else if (adv && en) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/vld_seq_ea.sv
// Effective address for the current element (combinational).
module vld_seq_ea
  import vld_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input  ld_mode_e      mode,
  input  logic          base_vec,
  input  logic [IW-1:0] i_idx,
  input  logic [AW-1:0] imm,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] off_val,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] i_w;

  assign i_w = AW'(i_idx);

  always_comb begin
    if (mode == M_INDEX) begin
      ea = base_val + off_val;                 // R8
    end else if (base_vec) begin
      ea = base_val + imm;                     // R4
    end else begin
      unique case (mode)
        M_UNIT:  ea = base_val + (i_w << op_size); // R5
        M_ELEM:  ea = base_val + i_w * imm;        // R6
        default: ea = base_val + imm;              // R7
      endcase
    end
  end
endmodule

// File: rtl/vld_addr_seq.sv
module vld_addr_seq
  import vld_seq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int VL_MAX = 8,
  parameter int IW     = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IW-1:0]     vl,
  input  logic [VL_MAX-1:0] src_pred,
  input  logic [VL_MAX-1:0] dst_pred,
  input  logic              base_vec,
  input  logic              off_vec,
  input  logic              dst_vec,
  input  logic [1:0]        mode,
  input  logic [AW-1:0]     imm,
  input  logic [1:0]        op_size,
  input  logic              upd_en,
  output logic [IW-1:0]     base_idx,
  output logic [IW-1:0]     off_idx,
  input  logic [AW-1:0]     base_rdata,
  input  logic [AW-1:0]     off_rdata,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [IW-1:0]     req_src_idx,
  output logic [IW-1:0]     req_dst_idx,
  output logic              req_upd,
  output logic [IW-1:0]     req_wb_idx
);
  localparam int NLANE = 3;               // 0: base i, 1: offset k, 2: dest j
  localparam logic [IW-1:0] VL_CAP = IW'(VL_MAX);

  seq_state_e state;

  // captured configuration (R2)
  logic [IW-1:0]     cfg_vl;
  logic [VL_MAX-1:0] cfg_src_pred, cfg_dst_pred;
  logic              cfg_base_vec, cfg_off_vec, cfg_dst_vec, cfg_upd;
  ld_mode_e          cfg_mode;
  logic [AW-1:0]     cfg_imm;
  logic [1:0]        cfg_op_size;

  logic              take, scan, adv, last_elem, any_end, all_parked;
  logic [NLANE-1:0]  ln_en, ln_end, ln_park;
  logic [VL_MAX-1:0] ln_pred [NLANE];
  logic [IW-1:0]     ln_idx  [NLANE];
  logic [AW-1:0]     ea;

  assign busy = (state != S_IDLE);
  assign take = (state == S_IDLE) && start;

  // which indices step: i for vector base or a stride mode, k for vector offset in indexed mode
  assign ln_en[0]   = cfg_base_vec || (cfg_mode == M_UNIT) || (cfg_mode == M_ELEM);
  assign ln_en[1]   = (cfg_mode == M_INDEX) && cfg_off_vec;
  assign ln_en[2]   = cfg_dst_vec;
  assign ln_pred[0] = cfg_src_pred;
  assign ln_pred[1] = cfg_src_pred;
  assign ln_pred[2] = cfg_dst_pred;

  assign any_end    = |ln_end;            // R10
  assign all_parked = &ln_park;
  assign scan       = (state == S_SCAN) && !any_end;
  assign last_elem  = !cfg_dst_vec ||
                      ((cfg_mode == M_INDEX) && !cfg_base_vec && !cfg_off_vec); // R11
  assign adv        = (state == S_HOLD) && req_ready && !last_elem;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    vld_seq_stepper #(.VL_MAX(VL_MAX), .IW(IW)) u_step (
      .clk    (clk),
      .rst    (rst),
      .clear  (take),
      .en     (ln_en[g]),
      .scan   (scan),
      .adv    (adv),
      .vl     (cfg_vl),
      .pred   (ln_pred[g]),
      .idx    (ln_idx[g]),
      .at_end (ln_end[g]),
      .parked (ln_park[g])
    );
  end

  assign base_idx = cfg_base_vec ? ln_idx[0] : '0;
  assign off_idx  = cfg_off_vec  ? ln_idx[1] : '0;

  vld_seq_ea #(.AW(AW), .IW(IW)) u_ea (
    .mode     (cfg_mode),
    .base_vec (cfg_base_vec),
    .i_idx    (ln_idx[0]),
    .imm      (cfg_imm),
    .op_size  (cfg_op_size),
    .base_val (base_rdata),
    .off_val  (off_rdata),
    .ea       (ea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      req_valid    <= 1'b0;
      req_addr     <= '0;
      req_src_idx  <= '0;
      req_dst_idx  <= '0;
      req_upd      <= 1'b0;
      req_wb_idx   <= '0;
      cfg_vl       <= '0;
      cfg_src_pred <= '0;
      cfg_dst_pred <= '0;
      cfg_base_vec <= 1'b0;
      cfg_off_vec  <= 1'b0;
      cfg_dst_vec  <= 1'b0;
      cfg_upd      <= 1'b0;
      cfg_mode     <= M_SPLAT;
      cfg_imm      <= '0;
      cfg_op_size  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cfg_vl       <= (vl > VL_CAP) ? VL_CAP : vl;
          cfg_src_pred <= src_pred;
          cfg_dst_pred <= dst_pred;
          cfg_base_vec <= base_vec;
          cfg_off_vec  <= off_vec;
          cfg_dst_vec  <= dst_vec;
          cfg_upd      <= upd_en;
          cfg_mode     <= ld_mode_e'(mode);
          cfg_imm      <= imm;
          cfg_op_size  <= op_size;
          state        <= S_SCAN;
        end
        S_SCAN: begin
          if (any_end) begin
            state <= S_IDLE;
          end else if (all_parked) begin
            req_valid   <= 1'b1;
            req_addr    <= ea;
            req_src_idx <= ln_idx[0];
            req_dst_idx <= ln_idx[2];
            req_upd     <= cfg_upd;                       // R12
            req_wb_idx  <= cfg_base_vec ? ln_idx[0] : '0; // R12
            state       <= S_HOLD;
          end
        end
        S_HOLD: if (req_ready) begin                      // R3
          req_valid <= 1'b0;
          state     <= last_elem ? S_IDLE : S_SCAN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vld_addr_seq_chk.sv
module vld_addr_seq_chk
  import vld_seq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int VL_MAX = 8,
  parameter int IW     = $clog2(VL_MAX + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AW-1:0]     req_addr,
  input logic [IW-1:0]     req_src_idx,
  input logic [IW-1:0]     req_dst_idx,
  input logic [IW-1:0]     cfg_vl,
  input logic [VL_MAX-1:0] cfg_src_pred,
  input logic [VL_MAX-1:0] cfg_dst_pred,
  input logic              cfg_base_vec,
  input logic              cfg_dst_vec,
  input ld_mode_e          cfg_mode
);
  localparam logic [VL_MAX-1:0] ONE = {{(VL_MAX-1){1'b0}}, 1'b1};

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_src_idx) && $stable(req_dst_idx));

  p_splat_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && !cfg_base_vec && (cfg_mode == M_SPLAT) |-> req_src_idx == '0);

  p_dst_mask_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && cfg_dst_vec |-> |(cfg_dst_pred & (ONE << req_dst_idx)));

  p_src_mask_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && (cfg_base_vec || cfg_mode == M_UNIT || cfg_mode == M_ELEM)
      |-> |(cfg_src_pred & (ONE << req_src_idx)));

  p_in_range_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_dst_idx < cfg_vl) && (req_src_idx < cfg_vl));

  p_scalar_dst_end_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !cfg_dst_vec |=> !busy);
endmodule

bind vld_addr_seq vld_addr_seq_chk #(.AW(AW), .VL_MAX(VL_MAX), .IW(IW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_src_idx  (req_src_idx),
  .req_dst_idx  (req_dst_idx),
  .cfg_vl       (cfg_vl),
  .cfg_src_pred (cfg_src_pred),
  .cfg_dst_pred (cfg_dst_pred),
  .cfg_base_vec (cfg_base_vec),
  .cfg_dst_vec  (cfg_dst_vec),
  .cfg_mode     (cfg_mode)
);

// File: tb/vld_addr_seq_tb.sv
module vld_addr_seq_tb;
  localparam int AW = 32, VLM = 8, IW = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [IW-1:0] vl = '0;
  logic [VLM-1:0] src_pred = '0, dst_pred = '0;
  logic base_vec = 0, off_vec = 0, dst_vec = 0, upd_en = 0, req_ready = 0;
  logic [1:0] mode = '0, op_size = '0;
  logic [AW-1:0] imm = '0;
  logic [IW-1:0] base_idx, off_idx, req_src_idx, req_dst_idx, req_wb_idx;
  logic [AW-1:0] base_rdata, off_rdata, req_addr;
  logic busy, req_valid, req_upd;

  int n_chk = 0, n_bad = 0, cyc_total = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] breg(int x);
    return 32'h1000_0007 + 32'(x) * 32'h100;
  endfunction
  function automatic logic [31:0] oreg(int x);
    return 32'h40 + 32'(x) * 32'd3;
  endfunction

  assign base_rdata = breg(int'(base_idx));
  assign off_rdata  = oreg(int'(off_idx));

  vld_addr_seq #(.AW(AW), .VL_MAX(VLM)) u_dut (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .src_pred(src_pred),
    .dst_pred(dst_pred), .base_vec(base_vec), .off_vec(off_vec),
    .dst_vec(dst_vec), .mode(mode), .imm(imm), .op_size(op_size),
    .upd_en(upd_en), .base_idx(base_idx), .off_idx(off_idx),
    .base_rdata(base_rdata), .off_rdata(off_rdata), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_src_idx(req_src_idx), .req_dst_idx(req_dst_idx),
    .req_upd(req_upd), .req_wb_idx(req_wb_idx)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_bad++;
      $display("FAIL R10 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  logic [31:0] e_addr [16];
  int e_src [16], e_dst [16], e_wb [16];
  int e_n;

  task automatic model(int md, bit bv, bit ov, bit dv, logic [7:0] sp,
                       logic [7:0] dp, int vlin, int os, logic [31:0] im);
    int i = 0, k = 0, j = 0;
    int vc = (vlin > VLM) ? VLM : vlin;
    bit si = bv || md == 1 || md == 2;
    bit sk = (md == 3) && ov;
    e_n = 0;
    forever begin
      if (si) while (i < vc && !sp[i]) i++;
      if (sk) while (k < vc && !sp[k]) k++;
      if (dv) while (j < vc && !dp[j]) j++;
      if (i >= vc || k >= vc || j >= vc) break;
      if (md == 3)      e_addr[e_n] = breg(bv ? i : 0) + oreg(ov ? k : 0);
      else if (bv)      e_addr[e_n] = breg(i) + im;
      else if (md == 1) e_addr[e_n] = breg(0) + (32'(i) << os);
      else if (md == 2) e_addr[e_n] = breg(0) + 32'(i) * im;
      else              e_addr[e_n] = breg(0) + im;
      e_src[e_n] = i; e_dst[e_n] = j; e_wb[e_n] = bv ? i : 0;
      e_n++;
      if (!dv) break;
      if (md == 3 && !bv && !ov) break;
      if (si) i++;
      if (sk) k++;
      if (dv) j++;
    end
  endtask

  task automatic run(int md, bit bv, bit ov, bit dv, logic [7:0] sp,
                     logic [7:0] dp, int vlin, int os, logic [31:0] im, bit up);
    string atag, ntag;
    int got = 0;
    bit held = 0;
    logic [31:0] h_addr;
    logic [IW-1:0] h_dst;
    model(md, bv, ov, dv, sp, dp, vlin, os, im);
    atag = (md == 3) ? "R8" : bv ? "R4" : (md == 1) ? "R5" : (md == 2) ? "R6" : "R7";
    ntag = (!dv || (md == 3 && !bv && !ov)) ? "R11" : "R10";
    @(negedge clk);
    mode = 2'(md); base_vec = bv; off_vec = ov; dst_vec = dv;
    src_pred = sp; dst_pred = dp; vl = IW'(vlin); op_size = 2'(os);
    imm = im; upd_en = up; start = 1;
    @(negedge clk);
    start = 0;
    // R2: scramble every input while the sequence runs
    mode = ~mode; base_vec = ~bv; off_vec = ~ov; dst_vec = ~dv;
    src_pred = ~sp; dst_pred = ~dp; vl = IW'(vlin + 3); op_size = op_size + 1;
    imm = im + 32'd5; upd_en = ~up;
    for (int cyc = 0; cyc < 100; cyc++) begin
      req_ready = (cyc % 3) != 1;
      #1;
      if (held) begin
        check("R3", "stalled addr", req_addr, h_addr);
        check("R3", "stalled dst idx", req_dst_idx, h_dst);
      end
      if (!busy) begin
        check("R1", "valid while idle", req_valid, 0);
        start = 0;
        break;
      end
      start = (cyc == 1);  // R2: ignored while busy
      if (req_valid && req_ready) begin
        if (got < e_n) begin
          check(atag, "address", req_addr, e_addr[got]);
          check("R9", "src idx", req_src_idx, e_src[got]);
          check("R9", "dst idx", req_dst_idx, e_dst[got]);
          check("R12", "wb idx", req_wb_idx, e_wb[got]);
          check("R12", "upd flag", req_upd, up);
        end else begin
          check(ntag, "extra request", got, e_n);
        end
        got++;
      end
      held = req_valid && !req_ready;
      h_addr = req_addr; h_dst = req_dst_idx;
      @(negedge clk);
    end
    start = 0; req_ready = 0;
    check(ntag, "request count (R2 captured cfg)", got, e_n);
  endtask

  initial begin
    logic [7:0] pats [5];
    int vls [4];
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h81; pats[4] = 8'h3C;
    vls[0] = 0; vls[1] = 5; vls[2] = 8; vls[3] = 13;
    repeat (3) @(negedge clk);
    check("R1", "reset valid", req_valid, 0);
    check("R1", "reset busy", busy, 0);
    rst = 0;
    for (int md = 0; md < 4; md++)
      for (int fl = 0; fl < 8; fl++)
        for (int p = 0; p < 5; p++)
          for (int v = 0; v < 4; v++)
            run(md, fl[0], fl[1], fl[2], pats[p], pats[(p + 2) % 5], vls[v],
                (p + v) % 4, (p % 2 == 0) ? 32'hFFFF_FFF0 : 32'd12, fl[0] ^ fl[2]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule